// File: doc/BRIEF.md
# Edge-Programmable Tri-State PWM Bank

A bank of pulse-width channels that share one clock and one power-of-two prescaler. Each channel counts prescaled ticks from zero up to a programmable period and then wraps. Two compare points shape the waveform. When the count reaches the ACTIVE point the channel enters its active phase. When the count reaches the INACTIVE point the channel returns to its inactive phase. Each phase has its own 2-bit drive code, so in each phase the pin can be pulled low, driven high or released.

Channels whose run bits rise on the same clock edge start from count zero together and stay aligned from then on. Two such channels can form a differential pair. Give them the same period, release both in the inactive phase, and place the compare points of one channel after those of the other. The result is a pair of pulses with a non-overlap gap that is exact to the clock. Configuration written while a channel runs is held back until the next wrap. The outputs are one data bit and one output-enable bit per channel. A released pin is shown by the output-enable being low.

Top module: `edgepwm_bank`

## Requirements
- R1: While reset is asserted, and after it until a channel is started, every `oe_o` and `pin_o` bit is 0.
- R2: A channel starts at count 0, in the inactive phase, in the cycle after the clock edge that first samples its `run_i` bit high. Channels started on the same edge with the same settings produce identical outputs on every cycle.
- R3: The count runs from 0 to PERIOD-1 and then returns to 0. Each count value lasts 2^S clock cycles, where S is `presc_sel_i`. Any value of S above 8 acts as 8.
- R4: The phase becomes active in the cycle when the count equals ACTIVE, and inactive in the cycle when it equals INACTIVE. Between those points the phase holds. If ACTIVE equals INACTIVE, the phase is inactive.
- R5: Drive codes (bit 1 is the MSB): 2'b11 drives high (oe=1, pin=1); 2'b10 drives low (oe=1, pin=0); 2'b00 releases (oe=0, pin=0); 2'b01 is reserved and also releases. `pin_o` is never 1 while `oe_o` is 0.
- R6: Values written to PERIOD, ACTIVE, INACTIVE or either drive code while a channel runs take effect only from the count-0 cycle after the next wrap.
- R7: In the cycle after the edge that samples a channel's `run_i` low, that channel's `oe_o` and `pin_o` are 0.
- R8: Take two channels with period 1280, with compare points 0/600 and 640/1240, active code 2'b10 and inactive code 2'b00, started together with S=0. Each channel has `oe_o` high for exactly 600 cycles per period. Both are never high at once, and each 40-cycle gap between their active windows is released on both channels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| presc_sel_i | input | SELW | Prescaler exponent S, giving a tick every 2^S cycles |
| run_i | input | NCH | Per-channel run bits |
| period_i | input | NCH x CW | Counts per cycle, per channel |
| act_i | input | NCH x CW | Count at which the active phase begins |
| inact_i | input | NCH x CW | Count at which the inactive phase begins |
| act_code_i | input | NCH x 2 | Drive code for the active phase |
| inact_code_i | input | NCH x 2 | Drive code for the inactive phase |
| pin_o | output | NCH | Pin data value per channel |
| oe_o | output | NCH | Pin output-enable per channel |

## Verification
The outputs are decoded combinationally from registered state. The level for a given count is therefore visible throughout the cycle that follows the edge that loaded the count. For a cycle k after start, the bench computes the count as floor(k/2^S) mod PERIOD. It samples at the falling edge that falls inside that cycle. A stop is checked at the first falling edge after the edge that samples `run_i` low. A configuration change made while a channel runs is checked both before and after the wrap that applies it. The differential case is compared on every one of 2560 cycles against windows computed from the compare points.

// File: rtl/edgepwm_pkg.sv
package edgepwm_pkg;
  typedef logic [1:0] drive_code_t;

  localparam drive_code_t CODE_RELEASE = 2'b00;
  localparam drive_code_t CODE_RSVD    = 2'b01;
  localparam drive_code_t CODE_LOW     = 2'b10;
  localparam drive_code_t CODE_HIGH    = 2'b11;

  // A drive code enables the pad only when its upper bit is set.
  function automatic logic code_oe(drive_code_t c);
    return c[1];
  endfunction

  function automatic logic code_pin(drive_code_t c);
    return c[1] & c[0];
  endfunction
endpackage

// File: rtl/edgepwm_rstsync.sv
module edgepwm_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/edgepwm_tickgen.sv
module edgepwm_tickgen #(
  parameter int MAXLOG = 8,
  parameter int SELW   = $clog2(MAXLOG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [SELW-1:0] sel,
  output logic            tick
);
  logic [MAXLOG-1:0] pc_q, pc_d, mask;

  // Low S bits of the mask are set; S above MAXLOG saturates to all ones.
  always_comb begin
    for (int b = 0; b < MAXLOG; b++) mask[b] = (SELW'(b) < sel);
  end

  always_comb begin
    pc_d = en ? pc_q + MAXLOG'(1) : '0;
    tick = en && ((pc_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/edgepwm_chan.sv
module edgepwm_chan
  import edgepwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        tick,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] act_pt,
  input  logic [CW-1:0] inact_pt,
  input  drive_code_t act_code,
  input  drive_code_t inact_code,
  output logic        pin,
  output logic        oe,
  output logic        running,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] per_o
);
  logic          run_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d, ph_now;
  logic [CW-1:0] per_s, act_s, inact_s;
  drive_code_t   acode_s, icode_s, cur_code;
  logic          start, wrap, load;

  always_comb begin
    start  = run && !run_q;
    wrap   = run_q && tick && (cnt_q == per_s - CW'(1));
    load   = start || wrap;
    // Reaching INACTIVE wins over reaching ACTIVE on the same count.
    if (!run_q)                 ph_now = 1'b0;
    else if (cnt_q == inact_s)  ph_now = 1'b0;
    else if (cnt_q == act_s)    ph_now = 1'b1;
    else                        ph_now = ph_q;

    if (!run || start)          cnt_d = '0;
    else if (wrap)              cnt_d = '0;
    else if (tick)              cnt_d = cnt_q + CW'(1);
    else                        cnt_d = cnt_q;

    ph_d     = (!run || start) ? 1'b0 : ph_now;
    cur_code = ph_now ? acode_s : icode_s;
    oe       = run_q && code_oe(cur_code);
    pin      = run_q && code_pin(cur_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      run_q <= run;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_s   <= '0;
      act_s   <= '0;
      inact_s <= '0;
      acode_s <= CODE_RELEASE;
      icode_s <= CODE_RELEASE;
    end else if (load) begin
      per_s   <= period;
      act_s   <= act_pt;
      inact_s <= inact_pt;
      acode_s <= act_code;
      icode_s <= inact_code;
    end
  end

  assign running = run_q;
  assign cnt_o   = cnt_q;
  assign per_o   = per_s;
endmodule

// File: rtl/edgepwm_bank.sv
module edgepwm_bank #(
  parameter int NCH    = 2,
  parameter int CW     = 12,
  parameter int MAXLOG = 8,
  parameter int SELW   = $clog2(MAXLOG + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SELW-1:0]          presc_sel_i,
  input  logic [NCH-1:0]           run_i,
  input  logic [NCH-1:0][CW-1:0]   period_i,
  input  logic [NCH-1:0][CW-1:0]   act_i,
  input  logic [NCH-1:0][CW-1:0]   inact_i,
  input  logic [NCH-1:0][1:0]      act_code_i,
  input  logic [NCH-1:0][1:0]      inact_code_i,
  output logic [NCH-1:0]           pin_o,
  output logic [NCH-1:0]           oe_o
);
  logic                   rst_int_n;
  logic                   tick;
  logic [NCH-1:0]         ch_run;
  logic [NCH-1:0][CW-1:0] ch_cnt, ch_per;

  edgepwm_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  edgepwm_tickgen #(.MAXLOG(MAXLOG), .SELW(SELW)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (|ch_run),
    .sel   (presc_sel_i),
    .tick  (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    edgepwm_chan #(.CW(CW)) u_chan (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .run        (run_i[i]),
      .tick       (tick),
      .period     (period_i[i]),
      .act_pt     (act_i[i]),
      .inact_pt   (inact_i[i]),
      .act_code   (act_code_i[i]),
      .inact_code (inact_code_i[i]),
      .pin        (pin_o[i]),
      .oe         (oe_o[i]),
      .running    (ch_run[i]),
      .cnt_o      (ch_cnt[i]),
      .per_o      (ch_per[i])
    );
  end
endmodule

// File: rtl/edgepwm_bank_chk.sv
module edgepwm_bank_chk #(
  parameter int NCH = 2,
  parameter int CW  = 12
) (
  input logic                   clk,
  input logic                   rst_int_n,
  input logic [NCH-1:0]         run_i,
  input logic [NCH-1:0][CW-1:0] act_i,
  input logic [NCH-1:0][CW-1:0] inact_i,
  input logic [NCH-1:0][1:0]    inact_code_i,
  input logic [NCH-1:0]         pin_o,
  input logic [NCH-1:0]         oe_o,
  input logic [NCH-1:0]         ch_run,
  input logic [NCH-1:0][CW-1:0] ch_cnt,
  input logic [NCH-1:0][CW-1:0] ch_per
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_int_n)
      !run_i[i] |=> (!oe_o[i] && !pin_o[i])); // R7

    AST_PIN_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_int_n)
      pin_o[i] |-> oe_o[i]); // R5

    AST_START_INACTIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
      ($rose(run_i[i]) && (act_i[i] != '0 || inact_i[i] == '0))
        |=> (oe_o[i] == $past(inact_code_i[i][1]))); // R2

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
      (ch_run[i] && ch_per[i] != '0) |-> (ch_cnt[i] < ch_per[i])); // R3
  end
endmodule

bind edgepwm_bank edgepwm_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .run_i        (run_i),
  .act_i        (act_i),
  .inact_i      (inact_i),
  .inact_code_i (inact_code_i),
  .pin_o        (pin_o),
  .oe_o         (oe_o),
  .ch_run       (ch_run),
  .ch_cnt       (ch_cnt),
  .ch_per       (ch_per)
);

// File: tb/test_edgepwm_bank.sv
`timescale 1ns/1ps
module test_edgepwm_bank;
  localparam int NCH = 2, CW = 12, MAXLOG = 8, SELW = 4;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [SELW-1:0]        presc_sel_i;
  logic [NCH-1:0]         run_i;
  logic [NCH-1:0][CW-1:0] period_i, act_i, inact_i;
  logic [NCH-1:0][1:0]    act_code_i, inact_code_i;
  logic [NCH-1:0]         pin_o, oe_o;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  edgepwm_bank #(.NCH(NCH), .CW(CW), .MAXLOG(MAXLOG), .SELW(SELW)) i_edgepwm_bank (
    .clk(clk), .rst_n(rst_n), .presc_sel_i(presc_sel_i), .run_i(run_i),
    .period_i(period_i), .act_i(act_i), .inact_i(inact_i),
    .act_code_i(act_code_i), .inact_code_i(inact_code_i),
    .pin_o(pin_o), .oe_o(oe_o)
  );

  // {sel, period, active, inactive, act code, inact code, cycle k, exp oe, exp pin}
  localparam int NV = 17;
  localparam logic [57:0] VEC [NV] = '{
    {4'd0, 12'd10, 12'd2, 12'd5, 2'b11, 2'b00, 12'd0,   1'b0, 1'b0},
    {4'd0, 12'd10, 12'd2, 12'd5, 2'b11, 2'b00, 12'd2,   1'b1, 1'b1},
    {4'd0, 12'd10, 12'd2, 12'd5, 2'b11, 2'b00, 12'd4,   1'b1, 1'b1},
    {4'd0, 12'd10, 12'd2, 12'd5, 2'b11, 2'b00, 12'd5,   1'b0, 1'b0},
    {4'd0, 12'd10, 12'd2, 12'd5, 2'b11, 2'b00, 12'd12,  1'b1, 1'b1},
    {4'd2, 12'd10, 12'd2, 12'd5, 2'b10, 2'b11, 12'd7,   1'b1, 1'b1},
    {4'd2, 12'd10, 12'd2, 12'd5, 2'b10, 2'b11, 12'd8,   1'b1, 1'b0},
    {4'd0, 12'd10, 12'd0, 12'd3, 2'b10, 2'b01, 12'd0,   1'b1, 1'b0},
    {4'd0, 12'd10, 12'd0, 12'd3, 2'b10, 2'b01, 12'd3,   1'b0, 1'b0},
    {4'd0, 12'd10, 12'd7, 12'd2, 2'b11, 2'b10, 12'd0,   1'b1, 1'b0},
    {4'd0, 12'd10, 12'd7, 12'd2, 2'b11, 2'b10, 12'd7,   1'b1, 1'b1},
    {4'd0, 12'd10, 12'd7, 12'd2, 2'b11, 2'b10, 12'd11,  1'b1, 1'b1},
    {4'd0, 12'd10, 12'd7, 12'd2, 2'b11, 2'b10, 12'd12,  1'b1, 1'b0},
    {4'd0, 12'd10, 12'd3, 12'd3, 2'b11, 2'b10, 12'd3,   1'b1, 1'b0},
    {4'd8, 12'd4,  12'd1, 12'd3, 2'b11, 2'b00, 12'd255, 1'b0, 1'b0},
    {4'd8, 12'd4,  12'd1, 12'd3, 2'b11, 2'b00, 12'd256, 1'b1, 1'b1},
    {4'd15,12'd4,  12'd1, 12'd3, 2'b11, 2'b00, 12'd256, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [NCH-1:0] eoe, input logic [NCH-1:0] epin);
    checks++;
    if (oe_o !== eoe || pin_o !== epin) begin
      errors++;
      $display("FAIL %s: oe=%b pin=%b expected oe=%b pin=%b", tag, oe_o, pin_o, eoe, epin);
    end
  endtask

  task automatic cfg_all(input logic [SELW-1:0] s, input logic [CW-1:0] p, a, n,
                         input logic [1:0] ac, ic);
    presc_sel_i = s;
    for (int c = 0; c < NCH; c++) begin
      period_i[c] = p; act_i[c] = a; inact_i[c] = n;
      act_code_i[c] = ac; inact_code_i[c] = ic;
    end
  endtask

  task automatic stop_all();
    @(negedge clk);
    run_i = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    run_i = '0;
    cfg_all(0, 10, 2, 5, 2'b11, 2'b10);
    repeat (3) @(negedge clk);
    chk("R1 in reset", '0, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset idle", '0, '0);

    // Vector walk: both channels share settings, so lock step (R2) is checked too.
    for (int v = 0; v < NV; v++) begin
      logic [57:0] t;
      t = VEC[v];
      @(negedge clk);
      cfg_all(t[57:54], t[53:42], t[41:30], t[29:18], t[17:16], t[15:14]);
      run_i = '1;
      @(negedge clk);
      repeat (int'(t[13:2])) @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 vector %0d", v), {NCH{t[1]}}, {NCH{t[0]}});
      stop_all();
    end

    // R7: a driven output is released after the stop edge.
    @(negedge clk);
    cfg_all(0, 10, 2, 5, 2'b11, 2'b10);
    run_i = '1;
    @(negedge clk);
    chk("R7 driven before stop", '1, '0);
    run_i = '0;
    @(negedge clk);
    chk("R7 released after stop", '0, '0);
    @(negedge clk);

    // R6: change compare points mid-period; they apply after the wrap.
    @(negedge clk);
    cfg_all(0, 10, 2, 5, 2'b11, 2'b00);
    run_i = '1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 cycle 3 active", '1, '1);
    for (int c = 0; c < NCH; c++) begin act_i[c] = 8; inact_i[c] = 9; end
    repeat (2) @(negedge clk);
    chk("R6 cycle 5 old inactive point", '0, '0);
    repeat (3) @(negedge clk);
    chk("R6 cycle 8 new point held back", '0, '0);
    repeat (4) @(negedge clk);
    chk("R6 cycle 12 new settings", '0, '0);
    repeat (6) @(negedge clk);
    chk("R6 cycle 18 new active point", '1, '1);
    @(negedge clk);
    chk("R6 cycle 19 new inactive point", '0, '0);
    stop_all();

    // R8: differential pair over two full periods.
    @(negedge clk);
    presc_sel_i = '0;
    period_i[0] = 1280; act_i[0] = 0;   inact_i[0] = 600;
    period_i[1] = 1280; act_i[1] = 640; inact_i[1] = 1240;
    for (int c = 0; c < NCH; c++) begin act_code_i[c] = 2'b10; inact_code_i[c] = 2'b00; end
    run_i = '1;
    for (int k = 0; k < 2560; k++) begin
      int cnt;
      logic e0, e1;
      @(negedge clk);
      cnt = k % 1280;
      e0 = (cnt < 600);
      e1 = (cnt >= 640) && (cnt < 1240);
      chk($sformatf("R8 differential cycle %0d", k), {e1, e0}, 2'b00);
    end
    stop_all();
    chk("R1 idle after all tests", '0, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule